// File: doc/BRIEF.md
# Linear Inactive-Engine Performance Estimator

This block predicts how well the engine that is currently switched off would have performed over the quantum that just ended. When a quantum closes, the surrounding logic presents six event counts gathered on the running engine and pulses a start strobe. The block then forms a linear model from these counts: a bias term plus each count times its own weight. It returns the clamped result, together with a one-cycle valid strobe, a fixed number of cycles later.

Two coefficient sets are held, one per switching direction. The set is chosen by which engine is running when the strobe arrives. Each set starts out with constants fixed at build time. A small write port lets per-application coefficients be loaded into either set, and a per-set mode bit chooses whether the loaded coefficients or the built-in ones are used.

Top module: `perf_estimator`

## Requirements
- R1: While reset is held and on the first cycle after it, `est_valid_o` is 0 and `est_value_o` is 0. Reset also returns both sets to built-in mode and loads the built-in values into the programmable storage.
- R2: Coefficients are signed 16-bit values with 8 fraction bits. Counters are unsigned 16-bit. Counter k sits at `ctr_i[16k+15:16k]`, in this order: k=0 L2 misses, k=1 L2 hits, k=2 branch mispredicts, k=3 ILP, k=4 MLP, k=5 active cycles. The result is floor((c0 + sum over k of c(k+1)*count_k) / 256), where c0 is the bias.
- R3: `dir_i`=0 (big engine running, little engine modelled) selects set 0. `dir_i`=1 (little engine running, big engine modelled) selects set 1. `dir_i` is sampled together with the start strobe.
- R4: After an accepted start, `est_valid_o` is a single-cycle pulse in the eighth cycle. `est_value_o` keeps its value until the next result is produced.
- R5: A negative sum gives 0. A quotient above 65535 gives 65535.
- R6: Built-in values as (bias, c1..c6) in hex Q8.8. Set 0: 0200, FF00, 0020, FF80, 0180, 0040, 0010. Set 1: 0300, FFC0, 0030, FF40, 0200, 0100, 0018.
- R7: A write with `cfg_addr_i` 0 stores the bias, and addresses 1..6 store c1..c6 of the set named by `cfg_set_i`. Address 7 is the mode register: bit 0 = 1 uses the programmed values, bit 0 = 0 reverts the set to the built-in values. Programmed values are kept while in built-in mode.
- R8: Coefficients and mode are captured when a start is accepted. A write made during a computation affects only later starts.
- R9: A start strobe that arrives while a computation is in flight (the seven cycles after an accepted start) is ignored.
- R10: A write to one set leaves the other set's results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | End-of-quantum strobe |
| dir_i | input | 1 | Running engine: 0 big, 1 little |
| ctr_i | input | 96 | Six 16-bit event counts |
| cfg_we_i | input | 1 | Coefficient/mode write enable |
| cfg_set_i | input | 1 | Set addressed by the write |
| cfg_addr_i | input | 3 | 0 bias, 1..6 weights, 7 mode |
| cfg_wdata_i | input | 16 | Write data |
| est_valid_o | output | 1 | Result strobe |
| est_value_o | output | 16 | Clamped estimate |

## Verification
All-zero counts isolate the bias. Directed vectors put through both directions show that each direction reads its own set. Large counts against extreme weights reach both clamps, so saturation can be told apart from wrap-around. Writes, mode flips and second strobes issued during a computation separate capture-at-start behaviour from live reads of the coefficients. Random count vectors, mixed with random reprogramming of either set, cross-check every weight position and the isolation between the two sets.

// File: rtl/estm_pkg.sv
package estm_pkg;

    localparam int NCTR   = 6;
    localparam int NCOEF  = NCTR + 1;
    localparam int NSET   = 2;
    localparam int CTR_W  = 16;
    localparam int COEF_W = 16;
    localparam int FRAC_W = 8;
    localparam int EST_W  = 16;
    localparam int ADDR_W = $clog2(NCOEF + 1);
    localparam int ACC_W  = COEF_W + CTR_W + 1 + $clog2(NCOEF);
    localparam int LAT    = 8;
    localparam int STEP_W = $clog2(LAT + 1);
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NCOEF);

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [CTR_W-1:0]         ctr_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [EST_W-1:0]         est_t;

    typedef enum logic {
        DIR_BIG_RUNS    = 1'b0,
        DIR_LITTLE_RUNS = 1'b1
    } dir_e;

    typedef struct packed {
        logic              we;
        logic              set;
        logic [ADDR_W-1:0] addr;
        coef_t             data;
    } cfg_wr_t;

    // Built-in coefficients, Q8.8
    function automatic coef_t dflt_coef(input int set, input int idx);
        coef_t r;
        r = '0;
        if (set == 0) begin
            case (idx)
                0: r = 16'sh0200;
                1: r = 16'shFF00;
                2: r = 16'sh0020;
                3: r = 16'shFF80;
                4: r = 16'sh0180;
                5: r = 16'sh0040;
                6: r = 16'sh0010;
                default: r = '0;
            endcase
        end else begin
            case (idx)
                0: r = 16'sh0300;
                1: r = 16'shFFC0;
                2: r = 16'sh0030;
                3: r = 16'shFF40;
                4: r = 16'sh0200;
                5: r = 16'sh0100;
                6: r = 16'sh0018;
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    // Drop the fraction and clamp into the unsigned result range
    function automatic est_t sat_est(input acc_t acc);
        acc_t q;
        acc_t top;
        top = acc_t'((64'd1 << EST_W) - 64'd1);
        if (acc < 0) return '0;
        q = acc >>> FRAC_W;
        if (q > top) return '1;
        return q[EST_W-1:0];
    endfunction

endpackage

// File: rtl/est_coef_bank.sv
module est_coef_bank
    import estm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  cfg_wr_t               cfg_i,
    input  logic                  sel_i,
    output coef_t [NCOEF-1:0]     coef_o
);

    localparam int FLAT_W = NSET * NCOEF * COEF_W;

    logic [FLAT_W-1:0] prog_flat;
    logic [NSET-1:0]   use_prog_q;

    for (genvar gs = 0; gs < NSET; gs++) begin : g_set
        for (genvar gc = 0; gc < NCOEF; gc++) begin : g_coef
            coef_t word_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= dflt_coef(gs, gc);
                end else if (cfg_i.we && (cfg_i.set == 1'(gs))
                             && (cfg_i.addr == ADDR_W'(gc))) begin
                    word_q <= cfg_i.data;
                end
            end
            assign prog_flat[(gs*NCOEF+gc)*COEF_W +: COEF_W] = word_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                use_prog_q[gs] <= 1'b0;
            end else if (cfg_i.we && (cfg_i.set == 1'(gs))
                         && (cfg_i.addr == MODE_ADDR)) begin
                use_prog_q[gs] <= cfg_i.data[0];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NCOEF; i++) begin
            if (use_prog_q[sel_i]) begin
                coef_o[i] = prog_flat[(int'(sel_i)*NCOEF+i)*COEF_W +: COEF_W];
            end else begin
                coef_o[i] = dflt_coef(int'(sel_i), i);
            end
        end
    end

endmodule

// File: rtl/est_mac_seq.sv
module est_mac_seq
    import estm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  coef_t [NCOEF-1:0] coef_i,
    input  ctr_t  [NCTR-1:0]  ctr_i,
    output logic              busy_o,
    output logic              done_o,
    output acc_t              acc_o
);

    logic [STEP_W-1:0] step_q;
    coef_t [NCTR-1:0]  w_q;
    ctr_t  [NCTR-1:0]  x_q;
    acc_t              acc_q;
    logic              done_q;

    coef_t cur_w;
    ctr_t  cur_x;
    acc_t  prod;
    logic  in_mac;

    assign busy_o = (step_q != '0);
    assign done_o = done_q;
    assign acc_o  = acc_q;

    // One weight/counter pair per step, picked by the step count
    always_comb begin
        cur_w = '0;
        cur_x = '0;
        for (int i = 0; i < NCTR; i++) begin
            if (int'(step_q) == i + 1) begin
                cur_w = w_q[i];
                cur_x = x_q[i];
            end
        end
        in_mac = busy_o && (int'(step_q) <= NCTR);
        prod   = acc_t'(cur_w) * acc_t'({1'b0, cur_x});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            acc_q  <= '0;
            done_q <= 1'b0;
            w_q    <= '0;
            x_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_o && start_i) begin
                step_q <= STEP_W'(1);
                acc_q  <= acc_t'(coef_i[0]);
                for (int i = 0; i < NCTR; i++) begin
                    w_q[i] <= coef_i[i+1];
                end
                x_q <= ctr_i;
            end else if (busy_o) begin
                if (in_mac) begin
                    acc_q <= acc_q + prod;
                end
                if (int'(step_q) == LAT - 1) begin
                    step_q <= '0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + STEP_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/est_out_reg.sv
module est_out_reg
    import estm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  acc_t acc_i,
    output logic valid_o,
    output est_t value_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            value_o <= '0;
        end else begin
            valid_o <= done_i;
            if (done_i) begin
                value_o <= sat_est(acc_i);
            end
        end
    end

endmodule

// File: rtl/perf_estimator.sv
module perf_estimator
    import estm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    dir_i,
    input  logic [NCTR*CTR_W-1:0]   ctr_i,
    input  logic                    cfg_we_i,
    input  logic                    cfg_set_i,
    input  logic [ADDR_W-1:0]       cfg_addr_i,
    input  logic [COEF_W-1:0]       cfg_wdata_i,
    output logic                    est_valid_o,
    output logic [EST_W-1:0]        est_value_o
);

    cfg_wr_t           cfg;
    dir_e              dir;
    coef_t [NCOEF-1:0] coef_sel;
    ctr_t  [NCTR-1:0]  ctr_vec;
    logic              mac_busy;
    logic              mac_done;
    acc_t              mac_acc;

    assign cfg.we   = cfg_we_i;
    assign cfg.set  = cfg_set_i;
    assign cfg.addr = cfg_addr_i;
    assign cfg.data = cfg_wdata_i;
    assign dir      = dir_e'(dir_i);

    for (genvar k = 0; k < NCTR; k++) begin : g_ctr
        assign ctr_vec[k] = ctr_i[k*CTR_W +: CTR_W];
    end

    est_coef_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .cfg_i  (cfg),
        .sel_i  (dir == DIR_LITTLE_RUNS),
        .coef_o (coef_sel)
    );

    est_mac_seq u_mac (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .coef_i  (coef_sel),
        .ctr_i   (ctr_vec),
        .busy_o  (mac_busy),
        .done_o  (mac_done),
        .acc_o   (mac_acc)
    );

    est_out_reg u_out (
        .clk     (clk),
        .rst     (rst),
        .done_i  (mac_done),
        .acc_i   (mac_acc),
        .valid_o (est_valid_o),
        .value_o (est_value_o)
    );

endmodule

// File: rtl/est_chk.sv
module est_chk
    import estm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       valid,
    input logic [EST_W-1:0] value
);

    logic [STEP_W-1:0] age_q;

    // Cycles since the last accepted start
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (start && !busy) begin
            age_q <= STEP_W'(1);
        end else if (age_q != '0 && int'(age_q) != LAT) begin
            age_q <= age_q + STEP_W'(1);
        end else begin
            age_q <= '0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!valid && value == '0));

    // R4
    valid_on_time_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(age_q) == LAT) |=> valid);

    // R4
    valid_only_on_time_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (int'($past(age_q)) == LAT));

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R4
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(value));

    // R9
    busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

bind perf_estimator est_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .busy  (mac_busy),
    .valid (est_valid_o),
    .value (est_value_o)
);

// File: tb/tb_perf_estimator.sv
module tb_perf_estimator;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        dir_i;
    logic [95:0] ctr_i;
    logic        cfg_we_i;
    logic        cfg_set_i;
    logic [2:0]  cfg_addr_i;
    logic [15:0] cfg_wdata_i;
    logic        est_valid_o;
    logic [15:0] est_value_o;

    int checks = 0;
    int fails  = 0;

    logic signed [15:0] m_prog [2][7];
    bit                 m_use  [2];

    perf_estimator dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .dir_i       (dir_i),
        .ctr_i       (ctr_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_set_i   (cfg_set_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .est_valid_o (est_valid_o),
        .est_value_o (est_value_o)
    );

    always #2 clk = ~clk;

    // R6 table
    function automatic logic signed [15:0] tb_dflt(input bit s, input int i);
        logic [15:0] t0 [7] = '{16'h0200, 16'hFF00, 16'h0020, 16'hFF80, 16'h0180, 16'h0040, 16'h0010};
        logic [15:0] t1 [7] = '{16'h0300, 16'hFFC0, 16'h0030, 16'hFF40, 16'h0200, 16'h0100, 16'h0018};
        return s ? $signed(t1[i]) : $signed(t0[i]);
    endfunction

    function automatic logic signed [15:0] tb_coef(input bit s, input int i);
        return m_use[s] ? m_prog[s][i] : tb_dflt(s, i);
    endfunction

    // R2 and R5 reference
    function automatic int unsigned model_est(input bit s, input logic [95:0] cv);
        longint acc;
        acc = longint'(tb_coef(s, 0));
        for (int k = 0; k < 6; k++) begin
            acc += longint'(tb_coef(s, k + 1)) * longint'({1'b0, cv[k*16 +: 16]});
        end
        if (acc < 0) return 0;
        acc = acc >>> 8;
        if (acc > 65535) return 65535;
        return int'(acc);
    endfunction

    task automatic model_write(input bit s, input logic [2:0] a, input logic [15:0] d);
        if (a == 3'd7) m_use[s] = d[0];
        else m_prog[s][a] = $signed(d);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input bit s, input logic [2:0] a, input logic [15:0] d);
        cfg_we_i = 1'b1; cfg_set_i = s; cfg_addr_i = a; cfg_wdata_i = d;
        model_write(s, a, d);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // Called and returns at a falling edge
    task automatic run_chk(input bit d, input logic [95:0] cv, input bit mid_wr,
                           input bit ms, input logic [2:0] ma, input logic [15:0] md,
                           input bit mid_go, input string tag);
        int unsigned exp_v;
        bit early;
        exp_v = model_est(d, cv);
        early = 1'b0;
        start_i = 1'b1; dir_i = d; ctr_i = cv;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (est_valid_o) early = 1'b1;
            if (i == 1) start_i = 1'b0;
            if (i == 2 && mid_wr) begin
                cfg_we_i = 1'b1; cfg_set_i = ms; cfg_addr_i = ma; cfg_wdata_i = md;
                model_write(ms, ma, md);
            end
            if (i == 2 && mid_go) begin
                start_i = 1'b1; ctr_i = ~cv; dir_i = ~d;
            end
            if (i == 3) begin
                cfg_we_i = 1'b0; start_i = 1'b0;
            end
        end
        @(negedge clk);
        check(est_valid_o && !early, {tag, " R4 latency"}, int'(est_valid_o), 1);
        check(int'(est_value_o) == int'(exp_v), {tag, " value"}, int'(est_value_o), int'(exp_v));
        @(negedge clk);
        check(!est_valid_o && int'(est_value_o) == int'(exp_v), {tag, " R4 hold"},
              int'(est_value_o), int'(exp_v));
    endtask

    function automatic logic [95:0] pack6(input int c0, input int c1, input int c2,
                                          input int c3, input int c4, input int c5);
        return {c5[15:0], c4[15:0], c3[15:0], c2[15:0], c1[15:0], c0[15:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R4 act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [95:0] v;
        void'($urandom(32'd20240607));
        rst = 1'b1; start_i = 1'b0; dir_i = 1'b0; ctr_i = '0;
        cfg_we_i = 1'b0; cfg_set_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
        for (int s = 0; s < 2; s++) begin
            m_use[s] = 1'b0;
            for (int i = 0; i < 7; i++) m_prog[s][i] = tb_dflt(s[0], i);
        end
        repeat (3) @(negedge clk);
        check(!est_valid_o && est_value_o == 16'd0, "R1 during reset", int'(est_value_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!est_valid_o && est_value_o == 16'd0, "R1 after reset", int'(est_value_o), 0);

        // R2: zero counts leave only the bias; R6 defaults
        run_chk(1'b0, '0, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R2 R6 bias set0");
        run_chk(1'b1, '0, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R3 R6 bias set1");
        v = pack6(3, 40, 5, 300, 20, 1000);
        run_chk(1'b0, v, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R3 R6 vec set0");
        run_chk(1'b1, v, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R3 R6 vec set1");
        for (int k = 0; k < 6; k++) begin
            v = '0;
            v[k*16 +: 16] = 16'd777;
            run_chk(k[0], v, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R2 single counter");
        end

        // R5 low clamp: many L2 misses against a negative weight
        run_chk(1'b0, pack6(65535, 0, 0, 0, 0, 0), 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R5 low clamp");
        // R5 high clamp: programmed large ILP weight
        cfg_write(1'b1, 3'd4, 16'h7FFF);
        cfg_write(1'b1, 3'd7, 16'h0001);
        run_chk(1'b1, pack6(0, 0, 0, 65535, 0, 0), 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R5 high clamp");

        // R7: programmed bias, revert, re-enable
        cfg_write(1'b0, 3'd0, 16'h1000);
        cfg_write(1'b0, 3'd7, 16'h0001);
        run_chk(1'b0, '0, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R7 programmed bias");
        cfg_write(1'b0, 3'd7, 16'h0000);
        run_chk(1'b0, '0, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R7 reverted");
        cfg_write(1'b0, 3'd7, 16'h0001);
        run_chk(1'b0, '0, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R7 programmed kept");

        // R10: set 0 change leaves set 1 alone
        cfg_write(1'b0, 3'd3, 16'h0400);
        run_chk(1'b1, pack6(1, 2, 50, 100, 3, 4), 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R10 other set");

        // R8: write to the set in use mid-computation, then the next run sees it
        run_chk(1'b0, '0, 1'b1, 1'b0, 3'd0, 16'h2000, 1'b0, "R8 mid write ignored");
        run_chk(1'b0, '0, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R8 write applied");
        run_chk(1'b0, '0, 1'b1, 1'b0, 3'd7, 16'h0000, 1'b0, "R8 mid mode ignored");
        run_chk(1'b0, '0, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R8 mode applied");

        // R9: second strobe while busy
        run_chk(1'b1, pack6(10, 20, 30, 40, 50, 60), 1'b0, 1'b0, 3'd0, 16'd0, 1'b1, "R9 start ignored");

        // Random mix with reprogramming
        for (int n = 0; n < 40; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                bit s;
                logic [2:0] a;
                logic [15:0] d;
                s = 1'($urandom_range(0, 1));
                a = 3'($urandom_range(0, 7));
                if ($urandom_range(0, 3) == 0) d = 16'($urandom);
                else d = 16'($signed($urandom_range(0, 1023)) - 512);
                cfg_write(s, a, d);
            end
            for (int k = 0; k < 6; k++) begin
                if ($urandom_range(0, 1) == 0) v[k*16 +: 16] = 16'($urandom);
                else v[k*16 +: 16] = 16'($urandom_range(0, 255));
            end
            run_chk(1'($urandom_range(0, 1)), v, 1'b0, 1'b0, 3'd0, 16'd0, 1'b0, "R2 R3 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule